// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a small serial memory on a two-wire bus. It samples the bus clock and data lines with a fast system clock and finds START and STOP conditions from them. Then it takes in a select byte and answers only when the device code and the three strap inputs match. It holds 128 bytes and serves single-byte writes, burst writes and sequential reads.

Written bytes first go into a staging buffer that is one 8-byte row deep. A STOP copies them into the array and starts a programming interval. While that interval runs, the block ignores its own select byte, so a host can poll to see when the write has finished. The interval is a count of system clocks. It doubles when the staged bytes fall in two different rows.

The data line is open-drain. `sda_oe_o` high means the block pulls SDA low, and the chip-level pad logic or the bench forms the wired-AND. The bus has no back-pressure of its own beyond the acknowledge bit. Every port here is a plain control or status pin.

Top module: `eep_slave`

## Requirements
- R1: The block acknowledges a select byte only if its bits 7:4 equal 4'b1010. Any other code gets no acknowledge, and the block stays off the bus until the next START.
- R2: Select bits 3:1 must equal `ce_i[2:0]`, with bit 3 compared to `ce_i[2]`. On a mismatch the byte gets no acknowledge.
- R3: Bit 0 of the select byte sets the direction (1 = read, 0 = write). The block acknowledges a matching select byte by asserting `sda_oe_o` during the ninth clock.
- R4: SDA falling while SCL is high (START) restarts select-byte decoding from any state. Staged write data that no STOP has committed is dropped. SDA rising while SCL is high (STOP) returns the block to idle.
- R5: A STOP after one or more data bytes inside a single 8-byte row holds `busy_o` high for exactly WR_CYCLES system clocks.
- R6: If the first and last staged addresses differ in bits 6:3, `busy_o` stays high for exactly 2×WR_CYCLES clocks.
- R7: While `busy_o` is high, a matching select byte gets no acknowledge and `sda_oe_o` stays low.
- R8: On a write, the byte after the select byte sets the 7-bit address pointer from its bits 6:0, and bit 7 is ignored. Each data byte is acknowledged and stored at the pointer, and the pointer then advances.
- R9: If a burst sends more than 8 data bytes, the pointer returns to the burst's first address. Later bytes overwrite earlier ones, and at most 8 addresses are written.
- R10: A read sends the byte at the pointer MSB first, and the pointer advances after each byte, wrapping from 127 to 0. A host acknowledge (SDA low on the ninth clock) starts the next byte.
- R11: A host no-acknowledge ends the read. The block releases SDA and does not drive it again until a new START.
- R12: `sda_oe_o` changes only while the sampled SCL is low.
- R13: After reset, `sda_oe_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 3 | Chip-enable straps compared with select bits 3:1 |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge or read data zero) |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The bench aims at the points where a burst write touches a row boundary. One burst starts two bytes before a row edge and another crosses from address 127 to 0; a design that compares the wrong address bits, or forgets the wrap, would report a single interval instead of a doubled one. A ten-byte burst checks that bytes 9 and 10 overwrite the first two addresses; a design with a linear pointer would instead write into the next row. A START in the middle of a write, with no STOP, must leave memory unchanged; a design that commits on START would store the discarded byte. Polling during the interval must be refused, the word-address MSB must be ignored, and a design that drove read data while SCL was high would show up as an SDA edge during a clock-high phase.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o   = scl_sh[STAGES-1];
  assign sda_o   = sda_sh[STAGES-1];
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/eep_row_stage.sv
module eep_row_stage #(
  parameter int ROW = 8,
  parameter int AW  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [7:0]               din_i,
  input  logic [AW-1:0]            base_i,
  output logic [ROW-1:0][7:0]      slot_o,
  output logic [ROW-1:0]           vld_o,
  output logic                     any_o,
  output logic                     span_o,
  output logic [AW-1:0]            ptr_nxt_o
);
  localparam int IW = (ROW > 1) ? $clog2(ROW) : 1;
  localparam int RB = $clog2(ROW);
  localparam int FW = $clog2(ROW + 1);

  logic [IW-1:0] widx, widx_nxt;
  logic [FW-1:0] nfill;
  logic [AW-1:0] last_addr;

  assign widx_nxt  = (widx == IW'(ROW - 1)) ? '0 : widx + 1'b1;
  assign ptr_nxt_o = base_i + AW'(widx_nxt);
  assign last_addr = base_i + AW'(nfill - FW'(1));
  assign span_o    = (nfill != '0) && (base_i[AW-1:RB] != last_addr[AW-1:RB]);
  assign any_o     = |vld_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx  <= '0;
      nfill <= '0;
    end else if (clr_i) begin
      widx  <= '0;
      nfill <= '0;
    end else if (push_i) begin
      widx <= widx_nxt;
      if (nfill != FW'(ROW)) nfill <= nfill + 1'b1;
    end
  end

  for (genvar g = 0; g < ROW; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_o[g] <= '0;
        vld_o[g]  <= 1'b0;
      end else if (clr_i) begin
        vld_o[g] <= 1'b0;
      end else if (push_i && widx == IW'(g)) begin
        slot_o[g] <= din_i;
        vld_o[g]  <= 1'b1;
      end
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    nfill <= FW'(ROW)); // R9
  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |=> vld_o[$past(widx)]); // R8
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int WR_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  logic dbl_i,
  output logic busy_o
);
  localparam int CW = $clog2(2 * WR_CYCLES + 1);
  localparam logic [CW-1:0] T_ONE = CW'(WR_CYCLES);
  localparam logic [CW-1:0] T_TWO = CW'(2 * WR_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (ld_i)        cnt <= dbl_i ? T_TWO : T_ONE;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && dbl_i) |=> cnt == T_TWO); // R6
  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ld_i) |=> cnt == $past(cnt) - 1'b1); // R5
endmodule

// File: rtl/eep_slave.sv
module eep_slave #(
  parameter int WR_CYCLES = 2500000,
  parameter int ROW       = 8,
  parameter int AW        = 7,
  parameter int SYNC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ce_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  import eep_pkg::*;

  localparam int         DEPTH    = 1 << AW;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  eep_state_e state, ack_next;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [AW-1:0] ptr, base;
  logic          more;
  logic [7:0]    mem [DEPTH];

  logic               byte_in, dev_hit, push, clr, commit, st_any, st_span;
  logic [ROW-1:0][7:0] st_slot;
  logic [ROW-1:0]     st_vld;
  logic [AW-1:0]      ptr_after;

  eep_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  assign byte_in = scl_fall && cnt == 4'd8 &&
                   (state == ST_DEV || state == ST_ADDR || state == ST_WDATA);
  assign dev_hit = sh[7:4] == DEV_CODE && sh[3:1] == ce_i && !busy_o;
  assign push    = byte_in && state == ST_WDATA;
  assign clr     = bus_start || bus_stop || (byte_in && state == ST_ADDR);
  assign commit  = bus_stop && st_any;

  eep_row_stage #(.ROW(ROW), .AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .push_i(push), .din_i(sh),
    .base_i(base), .slot_o(st_slot), .vld_o(st_vld), .any_o(st_any),
    .span_o(st_span), .ptr_nxt_o(ptr_after)
  );

  eep_prog_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .ld_i(commit), .dbl_i(st_span), .busy_o(busy_o)
  );

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < ROW; i++) begin
        if (st_vld[i]) mem[base + AW'(i)] <= st_slot[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      base     <= '0;
      more     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (bus_start) begin
      state    <= ST_DEV;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else if (bus_stop) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_in) begin
            if (state == ST_DEV) begin
              if (dev_hit) begin
                sda_oe_o <= 1'b1;
                state    <= ST_ACK;
                ack_next <= sh[0] ? ST_RDATA : ST_ADDR;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (state == ST_ADDR) begin
                ptr  <= sh[AW-1:0];
                base <= sh[AW-1:0];
              end else begin
                ptr <= ptr_after;
              end
              sda_oe_o <= 1'b1;
              state    <= ST_ACK;
              ack_next <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (ack_next == ST_RDATA) begin
              sh       <= mem[ptr];
              sda_oe_o <= ~mem[ptr][7];
              state    <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ack_next;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= ST_RACK;
            end else begin
              sh       <= {sh[6:0], 1'b0};
              sda_oe_o <= ~sh[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            more <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (more) begin
              sh       <= mem[ptr];
              sda_oe_o <= ~mem[ptr][7];
              state    <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s); // R12
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe_o); // R11
endmodule

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
  localparam int WRC = 1000;
  localparam int Q   = 10;
  localparam logic [2:0] CE = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CE, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CE, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, fails = 0, busy_cnt = 0, r12_bad = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] ebuf [16];

  always #2 clk = ~clk;

  eep_slave #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(CE), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (rst_n && scl_m && prev_scl && sda_oe !== prev_oe) r12_bad++;
    prev_scl = scl_m;
    prev_oe  = sda_oe;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = (b == 1'b0);
  endtask

  task automatic recv(input bit ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(ack ? 1'b0 : 1'b1);
  endtask

  task automatic wait_idle(input int exp, input string rq);
    while (busy) @(negedge clk);
    chk(busy_cnt == exp, rq, busy_cnt, exp);
  endtask

  task automatic wr_burst(input logic [7:0] a, input int n, input int exp_busy, input string rq);
    bit ack;
    bus_start();
    send(SEL_W, ack); chk(ack, "R3 select ack", ack, 1);
    send(a, ack);     chk(ack, "R8 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], ack); chk(ack, "R8 data ack", ack, 1);
    end
    busy_cnt = 0;
    bus_stop();
    wait_idle(exp_busy, rq);
  endtask

  task automatic rd_seq(input logic [7:0] a, input int n, input string rq);
    bit ack;
    logic [7:0] d;
    bus_start();
    send(SEL_W, ack); chk(ack, "R3 select ack", ack, 1);
    send(a, ack);     chk(ack, "R8 address ack", ack, 1);
    bus_start();
    send(SEL_R, ack); chk(ack, "R3 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, d);
      chk(d === ebuf[i], rq, d, ebuf[i]);
    end
    bus_stop();
    wq();
    chk(sda_oe == 1'b0, "R11 released after no-ack", sda_oe, 0);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R13 sda_oe reset", sda_oe, 0);
    chk(busy == 1'b0, "R13 busy reset", busy, 0);
  endtask

  task automatic t_bad_select();
    bit ack;
    bus_start(); send(8'hBA, ack); chk(!ack, "R1 wrong device code", ack, 0); bus_stop();
    bus_start(); send({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R2 wrong straps", ack, 0); bus_stop();
    bus_start(); send({4'b1010, 3'b001, 1'b1}, ack); chk(!ack, "R2 wrong straps read", ack, 0); bus_stop();
  endtask

  task automatic t_byte_write_poll();
    bit ack;
    bus_start();
    send(SEL_W, ack); chk(ack, "R3 select ack", ack, 1);
    send(8'h85, ack); chk(ack, "R8 address ack", ack, 1);
    send(8'h3C, ack); chk(ack, "R8 data ack", ack, 1);
    busy_cnt = 0;
    bus_stop();
    chk(busy == 1'b1, "R5 busy after stop", busy, 1);
    bus_start(); send(SEL_W, ack); chk(!ack, "R7 poll refused while busy", ack, 0); bus_stop();
    wait_idle(WRC, "R5 single interval");
    bus_start(); send(SEL_W, ack); chk(ack, "R7 poll accepted after busy", ack, 1); bus_stop();
    ebuf[0] = 8'h3C;
    rd_seq(8'h05, 1, "R8 address bit7 ignored / R10 read");
  endtask

  task automatic t_multi_row();
    for (int i = 0; i < 4; i++) begin
      wbuf[i] = 8'h11 * (i + 1);
      ebuf[i] = wbuf[i];
    end
    wr_burst(8'h10, 4, WRC, "R6 one row not doubled");
    rd_seq(8'h10, 4, "R10 sequential read");
  endtask

  task automatic t_span();
    for (int i = 0; i < 4; i++) begin
      wbuf[i] = 8'hA1 + 8'(i);
      ebuf[i] = wbuf[i];
    end
    wr_burst(8'h1E, 4, 2 * WRC, "R6 two rows doubled");
    rd_seq(8'h1E, 4, "R10 read across rows");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 10; i++) wbuf[i] = 8'h50 + 8'(i);
    for (int i = 0; i < 8; i++) ebuf[i] = 8'h50 + 8'(i);
    ebuf[0] = 8'h58;
    ebuf[1] = 8'h59;
    wr_burst(8'h20, 10, WRC, "R9 overflow stays in one row");
    rd_seq(8'h20, 8, "R9 overflow overwrite");
  endtask

  task automatic t_top_wrap();
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    ebuf[0] = 8'hE1; ebuf[1] = 8'hE2;
    wr_burst(8'h7F, 2, 2 * WRC, "R6 wrap 127 to 0 doubled");
    rd_seq(8'h7F, 2, "R10 read wraps 127 to 0");
  endtask

  task automatic t_abort();
    bit ack;
    wbuf[0] = 8'h77;
    wr_burst(8'h30, 1, WRC, "R5 single byte interval");
    bus_start();
    send(SEL_W, ack); send(8'h30, ack); send(8'h99, ack);
    chk(ack, "R8 data ack before abort", ack, 1);
    busy_cnt = 0;
    bus_start();
    bus_stop();
    repeat (20) @(negedge clk);
    chk(busy_cnt == 0, "R4 restart drops staged data", busy_cnt, 0);
    ebuf[0] = 8'h77;
    rd_seq(8'h30, 1, "R4 memory unchanged after restart");
  endtask

  task automatic t_nack_release();
    bit ack;
    logic [7:0] d;
    bus_start();
    send(SEL_W, ack); send(8'h10, ack);
    bus_start();
    send(SEL_R, ack);
    recv(1'b0, d);
    chk(d == 8'h11, "R10 first byte", d, 8'h11);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sda_oe) begin
        chk(1'b0, "R11 drove after no-ack", 1, 0);
        break;
      end
    end
    bit_in(d[0]);
    chk(sda_oe == 1'b0 && d[0] == 1'b1, "R11 SDA stays released", d[0], 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_bad_select();
    t_byte_write_poll();
    t_multi_row();
    t_span();
    t_overflow();
    t_top_wrap();
    t_abort();
    t_nack_release();
    chk(r12_bad == 0, "R12 sda changed while SCL high", r12_bad, 0);
    summary();
    $finish;
  end
endmodule